// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This block gathers seven single-cycle event pulses from an audio codec (gain ramp completions on the DAC and headphone paths, jack detection and short-circuit detection) into a sticky flag register. A mask register decides which flags may reach the single interrupt line. A two-bit form field selects how that line behaves: an active-high level, an active-low level, or a one-cycle pulse.

Software reads the flags through a small register port and clears them by writing ones. Flags latch whether or not their source is masked, so a driver can poll masked events. The interrupt output comes from a register and follows the flag and mask state by one clock.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the flag register reads 0x00, the mask register reads 0x7F (all sources masked), the control register reads 0x00 and irq_o is low.
- R2: A pulse on evt_i[k] sets flag bit k at the next clock edge, whatever the mask holds. The bits, from 6 down to 0, are: short-circuit released, jack change, short-circuit, headphone ramp-up done, headphone ramp-down done, DAC gain-up done, DAC gain-down done. A set flag stays set until software clears it.
- R3: A write to address 0 (flags) clears every flag whose wr_data bit is 1 and leaves the others unchanged; writing 0x7F clears all seven.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The mask lives at address 1 with the same bit order as the flags; a 1 in mask bit k keeps flag k from reaching irq_o.
- R6: The form field is bits 7:6 of the control register at address 2; the other control bits read as 0. Forms 0 and 3 drive irq_o high one cycle after any unmasked flag is set, and low one cycle after none is.
- R7: Form 1 drives irq_o with the inverse of the form 0 level.
- R8: Form 2 drives irq_o high for exactly one cycle, one cycle after any bit of the unmasked flag vector goes from 0 to 1, whether through a new event or by clearing a mask bit; a flag that stays set produces no further pulse.
- R9: rd_data shows the register chosen by rd_sel in the same cycle: address 0 flags in bits 6:0, address 1 mask in bits 6:0, address 2 form in bits 7:6, address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_sel |
| irq_o | output | 1 | Interrupt output |

## Verification
The pulse-form assertion treats a cycle with no event and no write as one in which the unmasked flag vector cannot change. It depends on every flag and mask change coming through evt_i or the write port, and on nothing else. The stimulus drives events and writes only at falling edges and holds each for a single cycle, so each change lands at a known edge. Full mask sweeps against two flag patterns, and every form value, are checked against levels worked out in the bench.

// File: rtl/codec_irq_unit.sv
module codec_irq_unit #(
  parameter int NUM_SRC = 7,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_sel,
  output logic [DW-1:0]      rd_data,
  output logic               irq_o
);
  localparam logic [1:0] SEL_FLAG = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [NUM_SRC-1:0] MASK_RST = '1;

  typedef enum logic [1:0] {
    FORM_HIGH     = 2'd0,
    FORM_LOW      = 2'd1,
    FORM_PULSE    = 2'd2,
    FORM_HIGH_ALT = 2'd3
  } form_e;

  logic [NUM_SRC-1:0] flag_q, mask_q, act_q;
  form_e              form_q;
  logic [NUM_SRC-1:0] clr, act;
  logic               wr_flag, wr_mask, wr_ctrl, pending, fresh, irq_d;

  assign wr_flag = wr_en && (wr_sel == SEL_FLAG);
  assign wr_mask = wr_en && (wr_sel == SEL_MASK);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign clr     = wr_flag ? wr_data[NUM_SRC-1:0] : '0;
  assign act     = flag_q & ~mask_q;
  assign pending = |act;
  assign fresh   = |(act & ~act_q);

  always_comb begin
    case (form_q)
      FORM_LOW:   irq_d = ~pending;
      FORM_PULSE: irq_d = fresh;
      default:    irq_d = pending;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= MASK_RST;
      form_q <= FORM_HIGH;
      act_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt_i;
      if (wr_mask) mask_q <= wr_data[NUM_SRC-1:0];
      if (wr_ctrl) form_q <= form_e'(wr_data[DW-1 -: 2]);
      act_q  <= act;
      irq_o  <= irq_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_FLAG: rd_data = DW'(flag_q);
      SEL_MASK: rd_data = DW'(mask_q);
      SEL_CTRL: rd_data = {form_q, {(DW-2){1'b0}}};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/codec_irq_unit_chk.sv
module codec_irq_unit_chk #(
  parameter int NUM_SRC = 7,
  parameter int DW      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [DW-1:0]      wr_data,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [1:0]         form_q
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && evt_i == '0) |=> ((flag_q & $past(wr_data[NUM_SRC-1:0])) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && (evt_i & wr_data[NUM_SRC-1:0]) != '0)
      |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (form_q != 2'd1 && (flag_q & ~mask_q) == '0) |=> !irq_o); // R5

  AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((form_q == 2'd0 || form_q == 2'd3) && (flag_q & ~mask_q) != '0) |=> irq_o); // R6

  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (form_q == 2'd1) |=> (irq_o == ($past(flag_q & ~mask_q) == '0))); // R7

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (form_q == 2'd2 && irq_o && $past(evt_i) == '0 && !$past(wr_en)) |=> !irq_o); // R8
endmodule

bind codec_irq_unit codec_irq_unit_chk #(.NUM_SRC(NUM_SRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .irq_o(irq_o), .flag_q(flag_q), .mask_q(mask_q),
  .form_q(form_q)
);

// File: tb/codec_irq_unit_bench.sv
module codec_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       irq;
  int errs = 0;
  int nchk = 0;

  always #4 clk = ~clk;

  codec_irq_unit u_codec_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input logic [6:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [6:0] acc;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(2'd0, v); chk("R1 flags", v, 8'h00);
    rd(2'd1, v); chk("R1 mask", v, 8'h7F);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd3, v); chk("R9 unused address", v, 8'h00);

    acc = '0;
    for (int i = 0; i < 7; i++) begin
      fire(7'(1 << i));
      acc |= 7'(1 << i);
      rd(2'd0, v); chk("R2 event sets flag under mask", v, {1'b0, acc});
    end
    idle(1);
    chk("R5 all masked keeps irq low", {7'd0, irq}, 8'h00);

    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R3 zero write keeps flags", v, 8'h7F);
    wr(2'd0, 8'h55);
    rd(2'd0, v); chk("R3 partial clear", v, 8'h2A);
    wr(2'd0, 8'h7F);
    rd(2'd0, v); chk("R3 clear all", v, 8'h00);

    @(negedge clk);
    evt = 7'h04; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h7F;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(2'd0, v); chk("R4 set beats clear", v, 8'h04);

    wr(2'd2, 8'h3F);
    rd(2'd2, v); chk("R6 ctrl low bits read zero", v, 8'h00);
    for (int p = 0; p < 2; p++) begin
      logic [6:0] fl;
      fl = (p == 0) ? 7'h2A : 7'h7F;
      wr(2'd0, 8'h7F);
      fire(fl);
      for (int m = 0; m < 128; m++) begin
        wr(2'd1, 8'(m));
        idle(1);
        chk("R5 mask sweep form0", {7'd0, irq}, {7'd0, ((fl & ~7'(m)) != 0)});
      end
    end

    wr(2'd1, 8'h7E);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk("R9 ctrl read form1", v, 8'h40);
    idle(1);
    chk("R7 low form pending", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h7F);
    idle(1);
    chk("R7 low form idle", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'hC0);
    idle(1);
    chk("R6 form3 idle", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h7E);
    idle(1);
    chk("R6 form3 pending", {7'd0, irq}, 8'h01);

    wr(2'd2, 8'hBF);
    rd(2'd2, v); chk("R6 form field only", v, 8'h80);
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h7F);
    idle(2);
    chk("R8 quiet start", {7'd0, irq}, 8'h00);
    fire(7'h08);
    chk("R8 no pulse yet", {7'd0, irq}, 8'h00);
    idle(1); chk("R8 pulse high", {7'd0, irq}, 8'h01);
    idle(1); chk("R8 pulse ends", {7'd0, irq}, 8'h00);
    idle(2); chk("R8 held flag no repeat", {7'd0, irq}, 8'h00);
    fire(7'h08);
    idle(2); chk("R8 repeat event no pulse", {7'd0, irq}, 8'h00);
    fire(7'h01);
    idle(1); chk("R8 second source pulse", {7'd0, irq}, 8'h01);
    idle(1); chk("R8 second pulse ends", {7'd0, irq}, 8'h00);
    fire(7'h20);
    idle(1); chk("R8 masked event no pulse", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    idle(1); chk("R8 unmask pulse", {7'd0, irq}, 8'h01);
    idle(1); chk("R8 unmask pulse ends", {7'd0, irq}, 8'h00);

    finish_run();
  end
endmodule